// File: doc/BRIEF.md
# Single-Cell Lithium Pack Protection Controller

This block decides, every clock, whether the charge switch and the discharge switch of a single-cell lithium pack may conduct. It receives already-digitized comparator results (cell above the overvoltage level, below the charge-enable level, below the undervoltage level, below the severe-depletion level; switch drop above the overcurrent level; pack terminal above the release level; charger present; over-temperature; wake switch pressed). Each fault is qualified by its own tick-based timer and released by its own condition.

The controller keeps sticky fault flags and two host enable bits in a protection register. It keeps a wake-switch flag and an over-temperature flag in an auxiliary register. It runs an active/sleep power mode. In sleep, both switches are forced off. A qualified undervoltage puts the block to sleep. A wake press or a charger wakes it, unless the cell is severely depleted. The outputs are the two switch enables, a test-current enable used to detect removal of a faulting load, and a recovery-charge enable. A slow `tick` strobe clocks all qualification delays.

Top module: `bpp_top`

## Requirements
- R1: After reset the block is asleep and all four enables are low. The protection register reads 0x53. Its layout is bit7 OV flag, bit6 UV flag, bit5 always 0, bit4 DOC flag, bit3 charge-switch mirror, bit2 discharge-switch mirror, bit1 CE, bit0 DE. The auxiliary register reads 0x80. Its layout is bit7 wake flag, bit0 OT flag, and the other bits 0.
- R2: In sleep, a wake press or a present charger moves the block to active, unless the cell is below the depletion level. On that transition CE and DE are set to 1, and the switches turn on the cycle after.
- R3: With the cell above the overvoltage level for OV_DLY consecutive ticks, the OV flag sets and the charge switch turns off. The discharge switch stays on.
- R4: An overvoltage hold ends when the cell is below the charge-enable level, or when the switch drop exceeds the overcurrent level.
- R5: On the first active cycle after a wake, a cell above the overvoltage level trips the overvoltage hold without any delay.
- R6: With the cell below the undervoltage level but not below the depletion level for UV_DLY ticks, the UV flag sets and the block enters sleep with both switches off. Undervoltage does not trip while the cell is below the depletion level.
- R7: With the switch drop above the overcurrent level for OC_DLY ticks, the DOC flag sets, both switches turn off and the test current turns on. The path is restored, and the test current stops, once the pack terminal is above the release level.
- R8: With the cell below the depletion level for SC_DLY ticks in active mode, the response is the same as R7.
- R9: A qualification timer restarts from zero whenever its condition drops before expiry.
- R10: Over-temperature turns both switches off one cycle after the input rises, with no delay, and sets OT. The switches return only after the input is low and the host has written OT to 0. A host write of 0 while over-temperature is high leaves OT at 1.
- R11: CE=0 forces the charge switch off, and DE=0 forces the discharge switch off, regardless of fault state.
- R12: The wake flag clears when the wake switch is pressed, in either mode. Only a host write of 1 to aux bit7 sets it again.
- R13: The recovery-charge enable is high when the cell is below the depletion level, or when the block is active with the cell below the charge-enable level.
- R14: A host write to the protection register loads OV, UV, DOC, CE and DE from the written bits. A hardware set in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow strobe that advances the qualification timers |
| wake_press | input | 1 | Wake switch is pressed |
| chg_present | input | 1 | Charger detected at the pack terminal |
| cell_ov | input | 1 | Cell above the overvoltage level |
| cell_below_ce | input | 1 | Cell below the charge-enable level |
| cell_uv | input | 1 | Cell below the undervoltage level |
| cell_sc | input | 1 | Cell below the severe-depletion level |
| drop_oc | input | 1 | Switch drop above the overcurrent level |
| pack_rel | input | 1 | Pack terminal above the release level |
| over_temp | input | 1 | Die temperature above the limit |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 selects the protection register, 1 the auxiliary register |
| reg_wdata | input | 8 | Host write data |
| chg_sw_en | output | 1 | Charge switch enable |
| dsg_sw_en | output | 1 | Discharge switch enable |
| test_cur_en | output | 1 | Load-removal test current enable |
| recov_chg_en | output | 1 | Recovery-charge path enable |
| pwr_active | output | 1 | 1 in active mode, 0 in sleep |
| prot_reg | output | 8 | Protection register read value |
| aux_reg | output | 8 | Auxiliary register read value |

## Verification
The bench interrupts an overvoltage and then resumes it, so that the total time exceeds the delay while no single run does. A timer that failed to restart would trip early. It wakes the block with the cell already above the overvoltage level. A design that applied the normal delay there would leave charging on for several more cycles. It holds undervoltage together with severe depletion, which a design with an ungated undervoltage timer would answer by falling asleep. It also clears OT while the temperature input is still high, which a design giving the host priority would answer by turning the switches back on while the die is still hot. Further cases cover a wake attempt during depletion, CE/DE being restored on wake after the host cleared them, and the two different overvoltage release paths.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  typedef enum logic {PM_SLEEP = 1'b0, PM_ACTIVE = 1'b1} pmode_e;

  localparam int NFLT = 4;
  localparam int F_OV = 0;
  localparam int F_UV = 1;
  localparam int F_OC = 2;
  localparam int F_SC = 3;

  // protection register bit positions
  localparam int PB_OV  = 7;
  localparam int PB_UV  = 6;
  localparam int PB_DOC = 4;
  localparam int PB_CCM = 3;
  localparam int PB_DCM = 2;
  localparam int PB_CE  = 1;
  localparam int PB_DE  = 0;

  // auxiliary register bit positions
  localparam int AB_WAKE = 7;
  localparam int AB_OT   = 0;
endpackage

// File: rtl/bpp_qual_timer.sv
module bpp_qual_timer #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cond,
  output logic done
);
  localparam int W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [W-1:0] LAST = W'(DELAY - 1);

  logic [W-1:0] cnt;

  // count ticks while the condition holds; any gap restarts the window
  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + W'(1);
    end
  end

  assign done = cond & tick & (cnt == LAST);
endmodule

// File: rtl/bpp_power_mode.sv
module bpp_power_mode
  import bpp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wake_req,
  input  logic   depleted,
  input  logic   uv_trip,
  output pmode_e mode,
  output logic   wake_go,
  output logic   first_eval
);
  pmode_e mode_q;

  assign wake_go = (mode_q == PM_SLEEP) & wake_req & ~depleted;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PM_SLEEP;
      first_eval <= 1'b0;
    end else begin
      first_eval <= wake_go;
      case (mode_q)
        PM_SLEEP:  if (wake_go) mode_q <= PM_ACTIVE;
        PM_ACTIVE: if (uv_trip) mode_q <= PM_SLEEP;
        default:   mode_q <= PM_SLEEP;
      endcase
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/bpp_top.sv
module bpp_top
  import bpp_pkg::*;
#(
  parameter int OV_DLY = 10000,
  parameter int UV_DLY = 1250,
  parameter int OC_DLY = 160,
  parameter int SC_DLY = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wake_press,
  input  logic       chg_present,
  input  logic       cell_ov,
  input  logic       cell_below_ce,
  input  logic       cell_uv,
  input  logic       cell_sc,
  input  logic       drop_oc,
  input  logic       pack_rel,
  input  logic       over_temp,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic       chg_sw_en,
  output logic       dsg_sw_en,
  output logic       test_cur_en,
  output logic       recov_chg_en,
  output logic       pwr_active,
  output logic [7:0] prot_reg,
  output logic [7:0] aux_reg
);
  localparam int DLY [NFLT] = '{OV_DLY, UV_DLY, OC_DLY, SC_DLY};

  pmode_e mode;
  logic   act, wake_go, first_eval;
  logic [NFLT-1:0] f_cond, f_done;

  logic ov_f, uv_f, doc_f, ce_q, de_q, ot_f, wk_f;
  logic ov_hold, doc_hold;
  logic cc_q, dc_q, tst_q, rcv_q;
  logic ov_set, doc_set, ot_blk;
  logic prot_wr, aux_wr;
  logic unused_wbits;

  assign act = (mode == PM_ACTIVE);

  bpp_power_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .wake_req   (wake_press | chg_present),
    .depleted   (cell_sc),
    .uv_trip    (f_done[F_UV]),
    .mode       (mode),
    .wake_go    (wake_go),
    .first_eval (first_eval)
  );

  // timers only run in active mode; undervoltage excludes deep depletion
  assign f_cond[F_OV] = act & cell_ov;
  assign f_cond[F_UV] = act & cell_uv & ~cell_sc;
  assign f_cond[F_OC] = act & drop_oc;
  assign f_cond[F_SC] = act & cell_sc;

  for (genvar g = 0; g < NFLT; g++) begin : g_qual
    bpp_qual_timer #(.DELAY(DLY[g])) u_qual (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .cond (f_cond[g]),
      .done (f_done[g])
    );
  end

  assign ov_set  = f_done[F_OV] | (first_eval & act & cell_ov);
  assign doc_set = f_done[F_OC] | f_done[F_SC];
  assign ot_blk  = ot_f | over_temp;
  assign prot_wr = reg_we & ~reg_sel;
  assign aux_wr  = reg_we & reg_sel;

  // flags and enables: host write first, hardware events override
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_f <= 1'b0; uv_f <= 1'b1; doc_f <= 1'b1;
      ce_q <= 1'b1; de_q <= 1'b1;
      ot_f <= 1'b0; wk_f <= 1'b1;
    end else begin
      if (prot_wr) begin
        ov_f  <= reg_wdata[PB_OV];
        uv_f  <= reg_wdata[PB_UV];
        doc_f <= reg_wdata[PB_DOC];
        ce_q  <= reg_wdata[PB_CE];
        de_q  <= reg_wdata[PB_DE];
      end
      if (aux_wr) begin
        wk_f <= reg_wdata[AB_WAKE];
        ot_f <= reg_wdata[AB_OT];
      end
      if (ov_set)       ov_f  <= 1'b1;
      if (f_done[F_UV]) uv_f  <= 1'b1;
      if (doc_set)      doc_f <= 1'b1;
      if (over_temp)    ot_f  <= 1'b1;
      if (wake_press)   wk_f  <= 1'b0;
      if (wake_go) begin
        ce_q <= 1'b1;
        de_q <= 1'b1;
      end
    end
  end

  // fault holds with their own release conditions
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_hold  <= 1'b0;
      doc_hold <= 1'b0;
    end else begin
      if (ov_set)                          ov_hold <= 1'b1;
      else if (cell_below_ce || drop_oc)   ov_hold <= 1'b0;
      if (doc_set)                         doc_hold <= 1'b1;
      else if (pack_rel)                   doc_hold <= 1'b0;
    end
  end

  // registered drive outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= 1'b0; dc_q <= 1'b0; tst_q <= 1'b0; rcv_q <= 1'b0;
    end else begin
      cc_q  <= act & ce_q & ~ov_hold & ~doc_hold & ~ot_blk;
      dc_q  <= act & de_q & ~doc_hold & ~ot_blk;
      tst_q <= act & doc_hold;
      rcv_q <= cell_sc | (act & cell_below_ce);
    end
  end

  assign unused_wbits = ^{reg_wdata[5], reg_wdata[3:2], reg_wdata[6:1]};

  assign chg_sw_en    = cc_q;
  assign dsg_sw_en    = dc_q;
  assign test_cur_en  = tst_q;
  assign recov_chg_en = rcv_q;
  assign pwr_active   = act;

  always_comb begin
    prot_reg         = '0;
    prot_reg[PB_OV]  = ov_f;
    prot_reg[PB_UV]  = uv_f;
    prot_reg[PB_DOC] = doc_f;
    prot_reg[PB_CCM] = cc_q;
    prot_reg[PB_DCM] = dc_q;
    prot_reg[PB_CE]  = ce_q;
    prot_reg[PB_DE]  = de_q;
    aux_reg          = '0;
    aux_reg[AB_WAKE] = wk_f;
    aux_reg[AB_OT]   = ot_f;
  end
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker (
  input logic clk,
  input logic rst,
  input logic act,
  input logic over_temp,
  input logic wake_press,
  input logic cell_sc,
  input logic ce,
  input logic de,
  input logic cc,
  input logic dc,
  input logic tst,
  input logic wk
);
  assert_sleep_switches_off_R6: assert property (@(posedge clk) disable iff (rst)
    !act |=> (!cc && !dc));

  assert_no_depleted_wake_R2: assert property (@(posedge clk) disable iff (rst)
    (!act && cell_sc) |=> !act);

  assert_wake_sets_enables_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> (ce && de));

  assert_ot_immediate_R10: assert property (@(posedge clk) disable iff (rst)
    over_temp |=> (!cc && !dc));

  assert_ce_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !cc);

  assert_de_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !de |=> !dc);

  assert_test_blocks_path_R7: assert property (@(posedge clk) disable iff (rst)
    tst |-> (!cc && !dc));

  assert_wake_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
    wake_press |=> !wk);
endmodule

bind bpp_top bpp_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .act        (act),
  .over_temp  (over_temp),
  .wake_press (wake_press),
  .cell_sc    (cell_sc),
  .ce         (ce_q),
  .de         (de_q),
  .cc         (cc_q),
  .dc         (dc_q),
  .tst        (tst_q),
  .wk         (wk_f)
);

// File: tb/bpp_top_test.sv
module bpp_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic wake_press = 0, chg_present = 0, cell_ov = 0, cell_below_ce = 0;
  logic cell_uv = 0, cell_sc = 0, drop_oc = 0, pack_rel = 0, over_temp = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = '0;
  logic chg_sw_en, dsg_sw_en, test_cur_en, recov_chg_en, pwr_active;
  logic [7:0] prot_reg, aux_reg;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  bpp_top #(.OV_DLY(6), .UV_DLY(5), .OC_DLY(4), .SC_DLY(3)) uut (
    .clk(clk), .rst(rst), .tick(tick),
    .wake_press(wake_press), .chg_present(chg_present),
    .cell_ov(cell_ov), .cell_below_ce(cell_below_ce), .cell_uv(cell_uv),
    .cell_sc(cell_sc), .drop_oc(drop_oc), .pack_rel(pack_rel),
    .over_temp(over_temp), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .chg_sw_en(chg_sw_en), .dsg_sw_en(dsg_sw_en),
    .test_cur_en(test_cur_en), .recov_chg_en(recov_chg_en),
    .pwr_active(pwr_active), .prot_reg(prot_reg), .aux_reg(aux_reg)
  );

  // stim {wake,chg,ov,below_ce,uv,sc,oc,rel,ot} | cycles | exp {act,cc,dc,tst,rcv} | prot | req
  localparam logic [29:0] TBL [0:15] = '{
    {9'h000, 4'd3, 5'b00000, 8'h53, 4'd1},  // R1 idle in sleep
    {9'h100, 4'd4, 5'b11100, 8'h5F, 4'd2},  // R2 wake press
    {9'h000, 4'd3, 5'b11100, 8'h5F, 4'd2},  // R2 stays active
    {9'h040, 4'd3, 5'b11100, 8'h5F, 4'd9},  // R9 short overvoltage
    {9'h000, 4'd1, 5'b11100, 8'h5F, 4'd9},  // R9 gap restarts timer
    {9'h040, 4'd5, 5'b11100, 8'h5F, 4'd9},  // R9 still under delay
    {9'h040, 4'd3, 5'b10100, 8'hD7, 4'd3},  // R3 overvoltage trips charge only
    {9'h000, 4'd3, 5'b10100, 8'hD7, 4'd3},  // R3 hold persists
    {9'h020, 4'd3, 5'b11101, 8'hDF, 4'd4},  // R4 release below charge-enable
    {9'h000, 4'd2, 5'b11100, 8'hDF, 4'd13}, // R13 recovery drops
    {9'h004, 4'd2, 5'b11100, 8'hDF, 4'd9},  // R9 short overcurrent
    {9'h004, 4'd4, 5'b10010, 8'hD3, 4'd7},  // R7 overcurrent trips
    {9'h000, 4'd3, 5'b10010, 8'hD3, 4'd7},  // R7 held until release
    {9'h002, 4'd3, 5'b11100, 8'hDF, 4'd7},  // R7 pack released
    {9'h001, 4'd2, 5'b10000, 8'hD3, 4'd10}, // R10 over-temperature
    {9'h000, 4'd3, 5'b10000, 8'hD3, 4'd10}  // R10 still off until host clears
  };

  task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic drive(input logic [8:0] s);
    {wake_press, chg_present, cell_ov, cell_below_ce, cell_uv,
     cell_sc, drop_oc, pack_rel, over_temp} = s;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hwrite(input logic sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc(1);
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {3'b000, pwr_active, chg_sw_en, dsg_sw_en, test_cur_en, recov_chg_en};
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    cyc(2);
    rst = 1'b0;
    #1;
    chk("R1 aux reset", aux_reg, 8'h80);
    for (int i = 0; i < 16; i++) begin
      drive(TBL[i][29:21]);
      cyc(int'(TBL[i][20:17]));
      chk($sformatf("R%0d step %0d outputs", TBL[i][3:0], i), outs(), {3'b000, TBL[i][16:12]});
      chk($sformatf("R%0d step %0d prot", TBL[i][3:0], i), prot_reg, TBL[i][11:4]);
    end
    // R10: host clear after temperature drops
    hwrite(1'b1, 8'h00);
    cyc(2);
    chk("R10 on after OT clear", outs(), 8'h1C);
    // R10: clear ignored while still hot
    drive(9'h001);
    cyc(1);
    hwrite(1'b1, 8'h00);
    chk("R10 OT kept while hot", aux_reg, 8'h01);
    drive(9'h000);
    cyc(2);
    chk("R10 still off", outs(), 8'h10);
    hwrite(1'b1, 8'h00);
    cyc(2);
    chk("R10 released", outs(), 8'h1C);
    // R14 host clears flags
    hwrite(1'b0, 8'h03);
    cyc(2);
    chk("R14 flags cleared", prot_reg, 8'h0F);
    // R11 CE and DE gating
    hwrite(1'b0, 8'h01);
    cyc(2);
    chk("R11 CE=0", prot_reg, 8'h05);
    hwrite(1'b0, 8'h02);
    cyc(2);
    chk("R11 DE=0", prot_reg, 8'h0A);
    // R6 undervoltage to sleep
    drive(9'h010);
    cyc(7);
    chk("R6 asleep", outs(), 8'h00);
    chk("R6 UV flag", prot_reg, 8'h42);
    // R2 no wake while depleted; R13 recovery in sleep
    drive(9'h108);
    cyc(4);
    chk("R2 depleted stays asleep", outs(), 8'h01);
    // R2 charger wakes, DE restored
    drive(9'h080);
    cyc(3);
    chk("R2 charger wake", outs(), 8'h1C);
    chk("R2 CE/DE restored", prot_reg, 8'h4F);
    // R5 zero overvoltage delay on wake
    drive(9'h010);
    cyc(7);
    drive(9'h140);
    cyc(3);
    chk("R5 immediate OV trip", outs(), 8'h14);
    chk("R5 prot", prot_reg, 8'hC7);
    // R4 release through discharge drop
    drive(9'h004);
    cyc(2);
    chk("R4 release by drop", outs(), 8'h1C);
    // R8 depletion trips; R6 undervoltage excluded during depletion
    drive(9'h018);
    cyc(5);
    chk("R8 depletion trip", outs(), 8'h13);
    chk("R8 prot", prot_reg, 8'hD3);
    drive(9'h002);
    cyc(3);
    chk("R7 released after depletion", outs(), 8'h1C);
    // R12 wake flag
    drive(9'h000);
    hwrite(1'b1, 8'h80);
    chk("R12 host sets wake flag", aux_reg, 8'h80);
    drive(9'h100);
    cyc(1);
    drive(9'h000);
    chk("R12 press clears wake flag", aux_reg, 8'h00);
    // R1 reset mid-run
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    chk("R1 outputs after reset", outs(), 8'h00);
    chk("R1 prot after reset", prot_reg, 8'h53);
    chk("R1 aux after reset", aux_reg, 8'h80);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule